// File: doc/BRIEF.md
# Interrupt Request and Error Controller

The block gathers the interrupt causes of a keypad companion into one interrupt code register and one error code register. It drives a single active-low request line to the host. The causes are a new key event, three kinds of error, and a signal change on either of two general-purpose input pins. Each of these causes arrives as a single-cycle pulse, except the pin changes, which the block detects itself.

The host reads the interrupt code through a read strobe. That read clears the code and releases the request line. The error code has its own read strobe, which clears only the error code. Each general-purpose pin passes through a two-flop synchronizer. After that, a rising or a falling edge raises an interrupt, but only if the pin's enable is set. A cause that arrives in the same cycle as a clearing read is kept, so no event can fall into the gap between the read and the clear.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, `int_code_o` is 0, `err_code_o` is 0 and `irq_no` is 1 (released).
- R2: A pulse on `key_evt_i` sets `int_code_o` bit 0 at the next clock edge, and `irq_no` goes low in that same cycle.
- R3: An error pulse sets its bit in `err_code_o` at the next edge. The bits are: bit 0 for `err_fifo_ovf_i`, bit 1 for `err_key_ovf_i` and bit 2 for `err_bad_cmd_i`. The same pulse sets `int_code_o` bit 1 and drives `irq_no` low.
- R4: When `gpio_en_i[n]` is 1, either a rising or a falling edge on `gpio_i[n]` sets `int_code_o` bit 2+n. Bit 2 belongs to pin 0 and bit 3 to pin 1. If the input changes just before clock edge k, the bit is set at edge k+2 and is still clear after edge k+1.
- R5: An edge on a pin whose enable is 0 leaves `int_code_o` unchanged, both at the point where it would have been set and afterwards.
- R6: Interrupt and error bits stay set, and `irq_no` stays low, until the matching read strobe arrives.
- R7: A pulse on `rd_int_i` clears `int_code_o` at the next edge and raises `irq_no`. It leaves `err_code_o` unchanged.
- R8: A pulse on `rd_err_i` clears `err_code_o` at the next edge. It leaves `int_code_o` unchanged.
- R9: If a cause arrives in the same cycle as the read that clears its register, the cause's bit is set after that edge and all other bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_evt_i | input | 1 | Single-cycle pulse: new key event |
| err_fifo_ovf_i | input | 1 | Single-cycle pulse: event buffer overrun |
| err_key_ovf_i | input | 1 | Single-cycle pulse: too many keys pressed |
| err_bad_cmd_i | input | 1 | Single-cycle pulse: invalid host command |
| gpio_i | input | 2 | Asynchronous general-purpose pins that can raise interrupts |
| gpio_en_i | input | 2 | Edge interrupt enable, one bit per pin |
| rd_int_i | input | 1 | Host read of the interrupt code; clears it |
| rd_err_i | input | 1 | Host read of the error code; clears it |
| int_code_o | output | 4 | Interrupt code: key, error, pin 0 edge, pin 1 edge |
| err_code_o | output | 3 | Error code: buffer overrun, key overrun, invalid command |
| irq_no | output | 1 | Interrupt request to the host, active low |

## Verification
The hardest case to reach is a cause that collides with the read that clears its register. The table therefore places key and error pulses in the same cycle as `rd_int_i` or `rd_err_i`. It also places both reads together with no cause present. The pin edges need exact timing through the synchronizer. The bench changes a pin and samples both one cycle before and at the expected set point. It repeats this with the pin's enable cleared, so that a disabled edge cannot slip through late.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NUM_GPIO    = 2;
  localparam int NUM_ERR     = 3;
  localparam int SYNC_STAGES = 2;
  // interrupt code bit positions
  localparam int INT_KEY  = 0;
  localparam int INT_ERR  = 1;
  localparam int INT_GPIO = 2;
  // error code bit positions
  localparam int ERR_FIFO = 0;
  localparam int ERR_KEYS = 1;
  localparam int ERR_CMD  = 2;
endpackage

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] edge_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh <= '0;
      else         sh <= {sh[STAGES-1:0], pin_i[g]};
    end
    assign edge_o[g] = en_i[g] & (sh[STAGES] ^ sh[STAGES-1]);
  end
endmodule

// File: rtl/sticky_bits.sv
module sticky_bits #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  // set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (clr_i ? '0 : q_o) | set_i;
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NGPIO = NUM_GPIO,
  parameter int NSYNC = SYNC_STAGES,
  localparam int INT_W = INT_GPIO + NGPIO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_evt_i,
  input  logic             err_fifo_ovf_i,
  input  logic             err_key_ovf_i,
  input  logic             err_bad_cmd_i,
  input  logic [NGPIO-1:0] gpio_i,
  input  logic [NGPIO-1:0] gpio_en_i,
  input  logic             rd_int_i,
  input  logic             rd_err_i,
  output logic [INT_W-1:0] int_code_o,
  output logic [NUM_ERR-1:0] err_code_o,
  output logic             irq_no
);
  logic [NGPIO-1:0]   gpio_edge;
  logic [NUM_ERR-1:0] err_set;
  logic [INT_W-1:0]   int_set;

  gpio_edge_det #(.N(NGPIO), .STAGES(NSYNC)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (gpio_i),
    .en_i  (gpio_en_i),
    .edge_o(gpio_edge)
  );

  always_comb begin
    err_set           = '0;
    err_set[ERR_FIFO] = err_fifo_ovf_i;
    err_set[ERR_KEYS] = err_key_ovf_i;
    err_set[ERR_CMD]  = err_bad_cmd_i;
    int_set           = '0;
    int_set[INT_KEY]  = key_evt_i;
    int_set[INT_ERR]  = |err_set;
    int_set[INT_W-1:INT_GPIO] = gpio_edge;
  end

  sticky_bits #(.W(NUM_ERR)) u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (err_set),
    .clr_i (rd_err_i),
    .q_o   (err_code_o)
  );

  sticky_bits #(.W(INT_W)) u_int (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (int_set),
    .clr_i (rd_int_i),
    .q_o   (int_code_o)
  );

  assign irq_no = ~|int_code_o;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int INT_W = 4,
  parameter int ERR_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             key_evt_i,
  input logic             err_fifo_ovf_i,
  input logic             err_key_ovf_i,
  input logic             err_bad_cmd_i,
  input logic             rd_int_i,
  input logic             rd_err_i,
  input logic [INT_W-1:0] int_code_o,
  input logic [ERR_W-1:0] err_code_o,
  input logic             irq_no
);
  logic any_err;
  assign any_err = err_fifo_ovf_i | err_key_ovf_i | err_bad_cmd_i;

  a_r2_key_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_evt_i |=> (int_code_o[0] && !irq_no));

  a_r3_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_err |=> (int_code_o[1] && (err_code_o != '0) && !irq_no));

  a_r6_int_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_int_i |=> ((int_code_o & $past(int_code_o)) == $past(int_code_o)));

  a_r7_rd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_int_i && !key_evt_i && !any_err) |=> (int_code_o[1:0] == 2'b00));

  a_r8_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_err_i && !any_err) |=> (err_code_o == '0));

  a_r9_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_int_i && key_evt_i) |=> (int_code_o[0] && !irq_no));
endmodule

bind irq_ctrl irq_ctrl_chk #(.INT_W(INT_W), .ERR_W(irq_ctrl_pkg::NUM_ERR)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .key_evt_i     (key_evt_i),
  .err_fifo_ovf_i(err_fifo_ovf_i),
  .err_key_ovf_i (err_key_ovf_i),
  .err_bad_cmd_i (err_bad_cmd_i),
  .rd_int_i      (rd_int_i),
  .rd_err_i      (rd_err_i),
  .int_code_o    (int_code_o),
  .err_code_o    (err_code_o),
  .irq_no        (irq_no)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       key_evt_i = 1'b0;
  logic [2:0] err_i = 3'b000;   // {bad_cmd, key_ovf, fifo_ovf}
  logic [1:0] gpio_i = 2'b00;
  logic [1:0] gpio_en_i = 2'b00;
  logic       rd_int_i = 1'b0;
  logic       rd_err_i = 1'b0;
  logic [3:0] int_code_o;
  logic [2:0] err_code_o;
  logic       irq_no;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk_i = ~clk_i;

  irq_ctrl u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .key_evt_i     (key_evt_i),
    .err_fifo_ovf_i(err_i[0]),
    .err_key_ovf_i (err_i[1]),
    .err_bad_cmd_i (err_i[2]),
    .gpio_i        (gpio_i),
    .gpio_en_i     (gpio_en_i),
    .rd_int_i      (rd_int_i),
    .rd_err_i      (rd_err_i),
    .int_code_o    (int_code_o),
    .err_code_o    (err_code_o),
    .irq_no        (irq_no)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [3:0] ei, input logic [2:0] ee,
                           input logic en);
    check(req, {int_code_o, err_code_o, irq_no}, {ei, ee, en});
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // {tag, key, err[2:0], rd_int, rd_err, exp_int[3:0], exp_err[2:0], exp_irqn}
  localparam int NV = 10;
  localparam logic [17:0] VECS [NV] = '{
    {4'd2, 1'b1, 3'b000, 1'b0, 1'b0, 4'b0001, 3'b000, 1'b0}, // R2 key sets bit 0
    {4'd6, 1'b0, 3'b000, 1'b0, 1'b0, 4'b0001, 3'b000, 1'b0}, // R6 held
    {4'd3, 1'b0, 3'b001, 1'b0, 1'b0, 4'b0011, 3'b001, 1'b0}, // R3 fifo overrun
    {4'd3, 1'b0, 3'b100, 1'b0, 1'b0, 4'b0011, 3'b101, 1'b0}, // R3 bad command
    {4'd8, 1'b0, 3'b000, 1'b0, 1'b1, 4'b0011, 3'b000, 1'b0}, // R8 err read
    {4'd7, 1'b0, 3'b000, 1'b1, 1'b0, 4'b0000, 3'b000, 1'b1}, // R7 int read
    {4'd9, 1'b1, 3'b000, 1'b1, 1'b0, 4'b0001, 3'b000, 1'b0}, // R9 key with read
    {4'd7, 1'b0, 3'b010, 1'b0, 1'b0, 4'b0011, 3'b010, 1'b0}, // R7 prep: key overrun
    {4'd9, 1'b0, 3'b010, 1'b1, 1'b1, 4'b0010, 3'b010, 1'b0}, // R9 error with both reads
    {4'd7, 1'b0, 3'b000, 1'b1, 1'b1, 4'b0000, 3'b000, 1'b1}  // R7 both reads clear
  };

  initial begin
    #400000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    clocks(2);
    check_all("R1 reset", 4'b0000, 3'b000, 1'b1);
    rst_ni = 1'b1;
    clocks(2);
    check_all("R1 after release", 4'b0000, 3'b000, 1'b1);

    for (int v = 0; v < NV; v++) begin
      {key_evt_i, err_i, rd_int_i, rd_err_i} = VECS[v][13:8];
      clocks(1);
      {key_evt_i, err_i, rd_int_i, rd_err_i} = '0;
      check_all($sformatf("R%0d vector %0d", VECS[v][17:14], v),
                VECS[v][7:4], VECS[v][3:1], VECS[v][0]);
    end

    // R4 rising edge on enabled pin 0: not after 2 edges, set after 3
    gpio_en_i = 2'b01;
    gpio_i[0] = 1'b1;
    clocks(2);
    check_all("R4 rise not early", 4'b0000, 3'b000, 1'b1);
    clocks(1);
    check_all("R4 rise pin0", 4'b0100, 3'b000, 1'b0);
    clocks(3);
    check_all("R6 gpio held", 4'b0100, 3'b000, 1'b0);
    rd_int_i = 1'b1; clocks(1); rd_int_i = 1'b0;
    check_all("R7 gpio cleared", 4'b0000, 3'b000, 1'b1);

    // R4 falling edge on pin 0
    gpio_i[0] = 1'b0;
    clocks(3);
    check_all("R4 fall pin0", 4'b0100, 3'b000, 1'b0);
    rd_int_i = 1'b1; clocks(1); rd_int_i = 1'b0;

    // R5 disabled pin 1 ignored
    gpio_i[1] = 1'b1;
    clocks(3);
    check_all("R5 disabled pin1 at set point", 4'b0000, 3'b000, 1'b1);
    clocks(4);
    check_all("R5 disabled pin1 later", 4'b0000, 3'b000, 1'b1);

    // R4 pin 1 enabled, falling edge
    gpio_en_i = 2'b10;
    gpio_i[1] = 1'b0;
    clocks(3);
    check_all("R4 fall pin1", 4'b1000, 3'b000, 1'b0);

    // R8 error read leaves gpio bit
    rd_err_i = 1'b1; clocks(1); rd_err_i = 1'b0;
    check_all("R8 err read keeps int", 4'b1000, 3'b000, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule